// File: doc/BRIEF.md
# Partitioned ternary match table

This block is a small ternary classification table. Every entry holds a value, a care mask and a valid bit. A lookup key is compared against all entries at once. A key bit takes part in the compare only where the entry's mask bit is 1, so mask bits at 0 are don't-care. When more than one entry hits, the entry with the lowest index is reported.

A privileged configuration side writes entries by absolute index, from 0 to capacity minus 1, and gives each system interface an entry count. Windows are laid out one after another: interface 0 starts at entry 0, and each later interface starts right after the last entry of the one before it. The base offsets are a prefix sum of the counts and follow any count write at once.

A lookup names its interface. Only entries inside that interface's window are considered, and the winning index is returned relative to the window base. The result is registered and arrives one cycle after the request. A one-bit configuration state machine watches the sum of the counts. It has two states, CFG_CLEAN and CFG_FAULT. Its only transition goes from CFG_CLEAN to CFG_FAULT, taken when the sum exceeds capacity. CFG_FAULT holds until reset. While the fault stands, a window that runs past the last entry reports no match.

Top module: `tmt_part_table`

## Requirements
- R1: After reset every entry is invalid, every interface count is 0, cfg_err is 0, and rs_valid, rs_hit and rs_idx are 0.
- R2: An entry hits a key when, for every bit where the entry mask is 1, the key bit equals the entry value bit; key bits where the mask is 0 are ignored.
- R3: An entry whose valid bit is 0 never hits, whatever its value and mask.
- R4: When several entries of the window hit, the one with the lowest absolute index is reported.
- R5: The base of interface n is the sum of the counts of interfaces 0 to n-1, and a lookup for n considers only the entries from base(n) to base(n)+count(n)-1.
- R6: On a hit, rs_idx equals the absolute index of the winning entry minus the base of the requesting interface.
- R7: rs_valid is 1 exactly in the cycle after a cycle with lk_req at 1. rs_hit and rs_idx are 0 whenever there is no hit or no request.
- R8: If the sum of all counts exceeds DEPTH, cfg_err rises on the next clock edge. It then stays 1 until reset, even if the counts are lowered again.
- R9: A lookup for an interface whose window end base+count exceeds DEPTH reports no hit. Interfaces whose windows fit keep working.
- R10: capacity always equals DEPTH (16 by default).
- R11: An entry or count write takes effect for lookups requested in later cycles. A lookup requested in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Absolute entry index to write |
| ent_value | input | KEY_W | Entry compare value |
| ent_mask | input | KEY_W | Entry care mask (1 = compare bit) |
| ent_valid | input | 1 | Entry valid bit |
| alloc_we | input | 1 | Interface count write strobe |
| alloc_if | input | IF_W | Interface whose count is written |
| alloc_cnt | input | CNT_W | Entry count for that interface |
| lk_req | input | 1 | Lookup request |
| lk_if | input | IF_W | Requesting interface (below NUM_IF) |
| lk_key | input | KEY_W | Lookup key |
| rs_valid | output | 1 | Result present (one cycle after request) |
| rs_hit | output | 1 | Lookup hit |
| rs_idx | output | IDX_W | Winning index local to the window |
| cfg_err | output | 1 | Sticky over-allocation flag |
| capacity | output | CNT_W | Number of table entries |

## Verification
A corrupted entry register or valid bit shows up on the first lookup whose window contains that entry. The lookup returns a wrong rs_hit, or a different local index, one cycle after the request. A wrong prefix sum moves a window: neighbouring interfaces then return offset indices or pick up entries from the wrong window, and for an interface at the edge the overrun rule fires or fails to fire. A wrong state in the configuration machine appears on cfg_err one edge after the count sum crosses capacity, or stays visible after the counts are lowered. The reference model compares all four result outputs in every cycle, so any such divergence is caught in the first cycle it reaches a port.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

    // Configuration health: clean until the allocations overflow the table.
    typedef enum logic [0:0] {
        CFG_CLEAN = 1'b0,
        CFG_FAULT = 1'b1
    } cfg_state_t;

endpackage

// File: rtl/tmt_entry_array.sv
module tmt_entry_array #(
    parameter int DEPTH = 16,
    parameter int KEY_W = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] key,
    output logic [DEPTH-1:0] hit_vec
);

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            logic [KEY_W-1:0] val_q;
            logic [KEY_W-1:0] msk_q;
            logic             vld_q;
            logic             sel;

            assign sel = wr_en && (wr_idx == IDX_W'(e));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                    msk_q <= '0;
                    vld_q <= 1'b0;
                end else if (sel) begin
                    val_q <= wr_value;
                    msk_q <= wr_mask;
                    vld_q <= wr_valid;
                end
            end

            // Compare only the bits the mask cares about.
            assign hit_vec[e] = vld_q && (((key ^ val_q) & msk_q) == '0);
        end
    endgenerate

endmodule

// File: rtl/tmt_window.sv
module tmt_window #(
    parameter int DEPTH  = 16,
    parameter int NUM_IF = 4,
    parameter int IF_W   = 2,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5,
    parameter int SUM_W  = 7
) (
    input  logic [CNT_W-1:0] alloc [NUM_IF],
    input  logic [IF_W-1:0]  sel_if,
    output logic [DEPTH-1:0] sel_mask,
    output logic [IDX_W-1:0] sel_base_lo,
    output logic             sel_over,
    output logic [SUM_W-1:0] total
);

    logic [SUM_W-1:0] base [NUM_IF];
    logic [SUM_W-1:0] lim  [NUM_IF];
    logic [SUM_W-1:0] sel_base;
    logic [SUM_W-1:0] sel_lim;

    // Running prefix sum: each window starts where the previous one ends.
    generate
        for (genvar i = 0; i < NUM_IF; i++) begin : g_pfx
            if (i == 0) begin : g_first
                assign base[i] = '0;
            end else begin : g_next
                assign base[i] = lim[i-1];
            end
            assign lim[i] = base[i] + SUM_W'(alloc[i]);
        end
    endgenerate

    assign total       = lim[NUM_IF-1];
    assign sel_base    = base[sel_if];
    assign sel_lim     = lim[sel_if];
    assign sel_base_lo = sel_base[IDX_W-1:0];
    assign sel_over    = sel_lim > SUM_W'(DEPTH);

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_msk
            assign sel_mask[e] = (SUM_W'(e) >= sel_base) && (SUM_W'(e) < sel_lim);
        end
    endgenerate

endmodule

// File: rtl/tmt_prio.sv
module tmt_prio #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the last assignment is the lowest set bit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tmt_part_table.sv
module tmt_part_table
    import tmt_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int NUM_IF = 4,
    parameter  int KEY_W  = 32,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IF_W   = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SUM_W  = $clog2(NUM_IF * ((1 << CNT_W) - 1) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_we,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic [KEY_W-1:0] ent_value,
    input  logic [KEY_W-1:0] ent_mask,
    input  logic             ent_valid,
    input  logic             alloc_we,
    input  logic [IF_W-1:0]  alloc_if,
    input  logic [CNT_W-1:0] alloc_cnt,
    input  logic             lk_req,
    input  logic [IF_W-1:0]  lk_if,
    input  logic [KEY_W-1:0] lk_key,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic [IDX_W-1:0] rs_idx,
    output logic             cfg_err,
    output logic [CNT_W-1:0] capacity
);

    logic [CNT_W-1:0] alloc_q [NUM_IF];
    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] sel_mask;
    logic [DEPTH-1:0] cand;
    logic [IDX_W-1:0] sel_base_lo;
    logic             sel_over;
    logic [SUM_W-1:0] total;
    logic             found;
    logic [IDX_W-1:0] win_idx;
    logic             lk_hit;
    logic [IDX_W-1:0] local_idx;
    cfg_state_t       state_q;
    cfg_state_t       state_d;

    // Per-interface allocation registers.
    generate
        for (genvar i = 0; i < NUM_IF; i++) begin : g_alloc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    alloc_q[i] <= '0;
                end else if (alloc_we && (alloc_if == IF_W'(i))) begin
                    alloc_q[i] <= alloc_cnt;
                end
            end
        end
    endgenerate

    tmt_entry_array #(
        .DEPTH (DEPTH),
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ent_we),
        .wr_idx   (ent_idx),
        .wr_value (ent_value),
        .wr_mask  (ent_mask),
        .wr_valid (ent_valid),
        .key      (lk_key),
        .hit_vec  (hit_vec)
    );

    tmt_window #(
        .DEPTH  (DEPTH),
        .NUM_IF (NUM_IF),
        .IF_W   (IF_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W),
        .SUM_W  (SUM_W)
    ) u_window (
        .alloc       (alloc_q),
        .sel_if      (lk_if),
        .sel_mask    (sel_mask),
        .sel_base_lo (sel_base_lo),
        .sel_over    (sel_over),
        .total       (total)
    );

    assign cand = hit_vec & sel_mask;

    tmt_prio #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_prio (
        .req   (cand),
        .found (found),
        .idx   (win_idx)
    );

    // Window offset fits in IDX_W bits because a winner lies inside the table.
    assign local_idx = win_idx - sel_base_lo;
    assign lk_hit    = found && !sel_over;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_idx   <= '0;
        end else begin
            rs_valid <= lk_req;
            rs_hit   <= lk_req && lk_hit;
            rs_idx   <= (lk_req && lk_hit) ? local_idx : '0;
        end
    end

    // Configuration health state machine.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_CLEAN: state_d = (total > SUM_W'(DEPTH)) ? CFG_FAULT : CFG_CLEAN;
            CFG_FAULT: state_d = CFG_FAULT;
            default:   state_d = CFG_FAULT;
        endcase
    end

    always_comb begin
        cfg_err  = (state_q == CFG_FAULT);
        capacity = CNT_W'(DEPTH);
    end

endmodule

// File: rtl/tmt_part_table_chk.sv
module tmt_part_table_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int SUM_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic [IDX_W-1:0] rs_idx,
    input logic             cfg_err,
    input logic [SUM_W-1:0] total,
    input logic             sel_over
);

    a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rs_valid);

    a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rs_valid);

    a_r7_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> (rs_idx == '0));

    a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_valid);

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r8_fault_on_excess: assert property (@(posedge clk) disable iff (!rst_n)
        (total > SUM_W'(DEPTH)) |=> cfg_err);

    a_r8_clean_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && (total <= SUM_W'(DEPTH))) |=> !cfg_err);

    a_r9_overrun_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && sel_over) |=> !rs_hit);

endmodule

bind tmt_part_table tmt_part_table_chk #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .SUM_W (SUM_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_idx   (rs_idx),
    .cfg_err  (cfg_err),
    .total    (total),
    .sel_over (sel_over)
);

// File: tb/tmt_part_table_test.sv
module tmt_part_table_test;

    localparam int DEPTH  = 16;
    localparam int NUM_IF = 4;
    localparam int KEY_W  = 32;
    localparam int IDX_W  = 4;
    localparam int IF_W   = 2;
    localparam int CNT_W  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ent_we = 1'b0;
    logic [IDX_W-1:0] ent_idx = '0;
    logic [KEY_W-1:0] ent_value = '0;
    logic [KEY_W-1:0] ent_mask = '0;
    logic             ent_valid = 1'b0;
    logic             alloc_we = 1'b0;
    logic [IF_W-1:0]  alloc_if = '0;
    logic [CNT_W-1:0] alloc_cnt = '0;
    logic             lk_req = 1'b0;
    logic [IF_W-1:0]  lk_if = '0;
    logic [KEY_W-1:0] lk_key = '0;
    logic             rs_valid;
    logic             rs_hit;
    logic [IDX_W-1:0] rs_idx;
    logic             cfg_err;
    logic [CNT_W-1:0] capacity;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    tmt_part_table uut (
        .clk (clk), .rst_n (rst_n),
        .ent_we (ent_we), .ent_idx (ent_idx), .ent_value (ent_value),
        .ent_mask (ent_mask), .ent_valid (ent_valid),
        .alloc_we (alloc_we), .alloc_if (alloc_if), .alloc_cnt (alloc_cnt),
        .lk_req (lk_req), .lk_if (lk_if), .lk_key (lk_key),
        .rs_valid (rs_valid), .rs_hit (rs_hit), .rs_idx (rs_idx),
        .cfg_err (cfg_err), .capacity (capacity)
    );

    // ---------------- behavioural reference model ----------------
    logic [KEY_W-1:0] m_val [DEPTH];
    logic [KEY_W-1:0] m_msk [DEPTH];
    bit               m_vld [DEPTH];
    int               m_alloc [NUM_IF];
    bit               e_valid, e_hit, e_err;
    int               e_idx;
    int               m_sum, m_base, m_end;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_val[i] = '0; m_msk[i] = '0; m_vld[i] = 0;
            end
            for (int k = 0; k < NUM_IF; k++) m_alloc[k] = 0;
            e_valid = 0; e_hit = 0; e_err = 0; e_idx = 0;
        end else begin
            m_sum = 0;
            for (int k = 0; k < NUM_IF; k++) m_sum += m_alloc[k];
            if (m_sum > DEPTH) e_err = 1;
            e_valid = lk_req; e_hit = 0; e_idx = 0;
            if (lk_req) begin
                m_base = 0;
                for (int k = 0; k < int'(lk_if); k++) m_base += m_alloc[k];
                m_end = m_base + m_alloc[lk_if];
                if (m_end <= DEPTH) begin
                    for (int i = m_base; i < m_end; i++) begin
                        if (!e_hit && m_vld[i] && (((lk_key ^ m_val[i]) & m_msk[i]) == '0)) begin
                            e_hit = 1; e_idx = i - m_base;
                        end
                    end
                end
            end
            if (ent_we) begin
                m_val[ent_idx] = ent_value; m_msk[ent_idx] = ent_mask; m_vld[ent_idx] = ent_valid;
            end
            if (alloc_we) m_alloc[alloc_if] = int'(alloc_cnt);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rs_valid == e_valid, "R7 model rs_valid", int'(rs_valid), int'(e_valid));
            chk(rs_hit == e_hit, "R4 model rs_hit", int'(rs_hit), int'(e_hit));
            chk(int'(rs_idx) == e_idx, "R6 model rs_idx", int'(rs_idx), e_idx);
            chk(cfg_err == e_err, "R8 model cfg_err", int'(cfg_err), int'(e_err));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_ent(input int idx, input logic [KEY_W-1:0] v,
                          input logic [KEY_W-1:0] m, input bit vl);
        @(negedge clk);
        ent_we = 1'b1; ent_idx = IDX_W'(idx); ent_value = v; ent_mask = m; ent_valid = vl;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic set_alloc(input int ifn, input int cnt);
        @(negedge clk);
        alloc_we = 1'b1; alloc_if = IF_W'(ifn); alloc_cnt = CNT_W'(cnt);
        @(negedge clk);
        alloc_we = 1'b0;
    endtask

    task automatic look(input int ifn, input logic [KEY_W-1:0] key,
                        input bit exp_hit, input int exp_idx, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_if = IF_W'(ifn); lk_key = key;
        @(negedge clk);
        lk_req = 1'b0;
        chk(rs_valid == 1'b1, {tag, " rs_valid"}, int'(rs_valid), 1);
        chk(rs_hit == exp_hit, {tag, " rs_hit"}, int'(rs_hit), int'(exp_hit));
        if (exp_hit) chk(int'(rs_idx) == exp_idx, {tag, " rs_idx"}, int'(rs_idx), exp_idx);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rs_valid == 1'b0 && rs_hit == 1'b0, "R1 reset result", int'(rs_valid), 0);
        chk(rs_idx == '0, "R1 reset idx", int'(rs_idx), 0);
        chk(cfg_err == 1'b0, "R1 reset cfg_err", int'(cfg_err), 0);
        chk(int'(capacity) == DEPTH, "R10 capacity", int'(capacity), DEPTH);
        rst_n = 1'b1;

        // R1: all entries start invalid, even with a full-width window.
        set_alloc(0, 16);
        look(0, 32'h0, 1'b0, 0, "R1 empty table");
        set_alloc(0, 4);
        set_alloc(1, 6);
        set_alloc(2, 4);
        set_alloc(3, 2);    // bases 0,4,10,14

        wr_ent(4, 32'h0, 32'h0, 1'b0);                 // invalid match-all
        wr_ent(5, 32'h0000_AB00, 32'h0000_FF00, 1'b1); // local 1 in if1
        wr_ent(7, 32'h0, 32'h0, 1'b1);                 // local 3 in if1
        look(1, 32'h1234_AB56, 1'b1, 1, "R2 masked compare");
        look(1, 32'h1234_AC56, 1'b1, 3, "R3 invalid entry skipped");

        wr_ent(4, 32'h0, 32'h0, 1'b1);
        look(1, 32'h1234_AB56, 1'b1, 0, "R4 lowest index wins");

        wr_ent(3, 32'h0, 32'h0, 1'b1);
        look(0, 32'hDEAD_BEEF, 1'b1, 3, "R6 local index if0");
        look(1, 32'h1234_AB56, 1'b1, 0, "R5 lower window ignored");
        look(2, 32'h1234_AB56, 1'b0, 0, "R5 other windows ignored");

        // R11: write and lookup in the same cycle.
        @(negedge clk);
        ent_we = 1'b1; ent_idx = 4'd10; ent_value = '0; ent_mask = '0; ent_valid = 1'b1;
        lk_req = 1'b1; lk_if = 2'd2; lk_key = 32'h5;
        @(negedge clk);
        ent_we = 1'b0; lk_req = 1'b0;
        chk(rs_hit == 1'b0, "R11 same-cycle write unseen", int'(rs_hit), 0);
        look(2, 32'h5, 1'b1, 0, "R11 write seen later");
        @(negedge clk);
        chk(rs_valid == 1'b0 && rs_hit == 1'b0, "R7 idle result", int'(rs_valid), 0);

        wr_ent(14, 32'h0, 32'h0, 1'b1);
        look(3, 32'h7, 1'b1, 0, "R6 local index if3");

        set_alloc(3, 4);    // total 18
        @(negedge clk);
        chk(cfg_err == 1'b1, "R8 over-allocation flag", int'(cfg_err), 1);
        look(3, 32'h7, 1'b0, 0, "R9 overrun window misses");
        look(2, 32'h7, 1'b1, 0, "R9 fitting window works");

        set_alloc(3, 2);
        look(3, 32'h7, 1'b1, 0, "R9 window fits again");
        chk(cfg_err == 1'b1, "R8 flag sticky", int'(cfg_err), 1);
        chk(int'(capacity) == DEPTH, "R10 capacity later", int'(capacity), DEPTH);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule